// File: doc/BRIEF.md
# Bidirectional Port Response Tester

This block tests an external device through an 8-line bidirectional digital port. After a start strobe it captures a stimulus byte, a drive duration and an expected byte. It then drives the stimulus onto the port for the given number of clock cycles. Next it turns off the output enable of every line and waits one turnaround cycle. It brings the device's reply through a two-flop synchronizer and compares it with the expected byte.

The result appears as a one-cycle done strobe and a match flag. The match flag holds until the next accepted start. The tester keeps no state outside its own instance, so one copy can be placed per port and all copies run in parallel. The port pins are split into output data, output enable and input data. The tristate pad belongs to the surrounding chip.

Top module: `bidir_port_tester`

## Requirements
- R1: After reset, `portOe` is 8'h00, `testDone` is 0 and `patternMatch` is 0.
- R2: A start strobe sampled while idle begins a test. From the next cycle, `portOe` is 8'hFF and `portOut` equals the captured stimulus byte.
- R3: The drive phase lasts `respCycles` clock cycles, with a minimum of one cycle: a value of 0 or 1 both give one drive cycle.
- R4: When the drive phase ends, every bit of `portOe` drops together and `portOut` reads 8'h00. The cycle that follows is a turnaround cycle. The reply compared is the `portIn` value at the end of the first cycle after that turnaround, so neither the tester's own driven data nor values after that point affect the result.
- R5: `patternMatch` is 1 exactly when the captured reply equals the expected byte that was captured at start.
- R6: `testDone` is high for exactly one cycle. With drive length D, this is cycle D+4 counted from the first drive cycle (cycle 0). `patternMatch` is valid from that cycle and holds until the next accepted start, which clears it to 0.
- R7: A start strobe sampled while a test is running is ignored. The running sequence and its timing are unchanged.
- R8: After a test starts, changes on `stimByte` and `expectByte` have no effect on that test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Start strobe, acted on only when idle |
| stimByte | input | 8 | Byte to drive onto the port |
| respCycles | input | 16 | Drive duration in clock cycles (0 treated as 1) |
| expectByte | input | 8 | Expected reply byte |
| portOut | output | 8 | Port output data |
| portOe | output | 8 | Per-line output enable, 1 = driving |
| portIn | input | 8 | Port input data from the pads |
| testDone | output | 1 | One-cycle end-of-test strobe |
| patternMatch | output | 1 | Reply equals expected byte |

## Verification
The bench models the pad with a loopback: while any enable is high, `portIn` shows the tester's own data. Once the port is released, `portIn` shows a device reply. During the turnaround cycle and again after the capture point, that reply is replaced by its complement. A result that agrees with the chosen reply therefore shows the capture happened in the one correct cycle.

Drive durations of 0, 1 and 5 separate the minimum-length rule from ordinary counting. Replies equal to and different from the expected byte, including one equal to the stimulus, separate a true compare from an echo of the driven data. One test strobes start and changes the inputs in mid-sequence, to show that both are ignored.

// File: rtl/tester_pkg.sv
package tester_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DRIVE,
    ST_RELEASE,
    ST_SAMPLE,
    ST_DONE
  } seq_state_e;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadCfg;   // capture stimulus / expected, clear result
    logic driveOn;   // port actively driven
    logic capture;   // compare synchronized reply this cycle
    logic doneOn;    // end-of-test strobe
  } seq_ctl_t;

endpackage

// File: rtl/port_seq_ctrl.sv
module port_seq_ctrl
  import tester_pkg::*;
#(
  parameter int CntW         = 16,
  parameter int SampleCycles = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            startPulse,
  input  logic [CntW-1:0] respCycles,
  output seq_ctl_t        ctl
);

  localparam int SampW = (SampleCycles > 1) ? $clog2(SampleCycles) : 1;
  localparam logic [SampW-1:0] SampLast = SampW'(SampleCycles - 1);

  seq_state_e      state, stateNext;
  logic [CntW-1:0] driveCnt;
  logic [SampW-1:0] sampCnt;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:    if (startPulse) stateNext = ST_DRIVE;
      ST_DRIVE:   if (driveCnt <= CntW'(1)) stateNext = ST_RELEASE;
      ST_RELEASE: stateNext = ST_SAMPLE;
      ST_SAMPLE:  if (sampCnt == '0) stateNext = ST_DONE;
      ST_DONE:    stateNext = ST_IDLE;
      default:    stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      driveCnt <= '0;
      sampCnt  <= '0;
    end else begin
      state <= stateNext;
      if (state == ST_IDLE && startPulse) driveCnt <= respCycles;
      else if (state == ST_DRIVE)         driveCnt <= driveCnt - CntW'(1);
      if (state == ST_RELEASE)            sampCnt  <= SampLast;
      else if (state == ST_SAMPLE)        sampCnt  <= sampCnt - SampW'(1);
    end
  end

  always_comb begin
    ctl.loadCfg = (state == ST_IDLE) && startPulse;
    ctl.driveOn = (state == ST_DRIVE);
    ctl.capture = (state == ST_SAMPLE) && (sampCnt == '0);
    ctl.doneOn  = (state == ST_DONE);
  end

  // R6: done state lasts one cycle and returns to idle
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_DONE |=> state == ST_IDLE);

  // R4: a turnaround cycle always directly follows the drive phase
  p_turnaround_r4: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_DRIVE && stateNext != ST_DRIVE |=> state == ST_RELEASE);

  // R7: a busy sequencer never re-enters drive from another state
  p_busy_ignore_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && state != ST_DRIVE) |=> state != ST_DRIVE);

endmodule

// File: rtl/port_seq_data.sv
module port_seq_data
  import tester_pkg::*;
#(
  parameter int PortW      = 8,
  parameter int SyncStages = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  seq_ctl_t         ctl,
  input  logic [PortW-1:0] stimByte,
  input  logic [PortW-1:0] expectByte,
  input  logic [PortW-1:0] portIn,
  output logic [PortW-1:0] portOut,
  output logic [PortW-1:0] portOe,
  output logic             testDone,
  output logic             patternMatch
);

  logic [PortW-1:0] stimReg, expReg;
  logic [PortW-1:0] syncChain [SyncStages];
  logic             matchReg;

  for (genvar s = 0; s < SyncStages; s++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rstN) syncChain[s] <= '0;
      else if (s == 0) syncChain[s] <= portIn;
      else syncChain[s] <= syncChain[(s == 0) ? 0 : s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stimReg  <= '0;
      expReg   <= '0;
      matchReg <= 1'b0;
    end else if (ctl.loadCfg) begin
      stimReg  <= stimByte;
      expReg   <= expectByte;
      matchReg <= 1'b0;
    end else if (ctl.capture) begin
      matchReg <= (syncChain[SyncStages-1] == expReg);
    end
  end

  assign portOe       = {PortW{ctl.driveOn}};
  assign portOut      = ctl.driveOn ? stimReg : '0;
  assign testDone     = ctl.doneOn;
  assign patternMatch = matchReg;

  // R6: result holds between capture and the next start
  p_match_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.capture && !ctl.loadCfg |=> $stable(matchReg));

  // R6: an accepted start clears the result
  p_match_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadCfg |=> !matchReg);

  // R8: captured configuration only changes at an accepted start
  p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.loadCfg |=> $stable(stimReg) && $stable(expReg));

endmodule

// File: rtl/bidir_port_tester.sv
module bidir_port_tester
  import tester_pkg::*;
#(
  parameter int PortW      = 8,
  parameter int CntW       = 16,
  parameter int SyncStages = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic [PortW-1:0] stimByte,
  input  logic [CntW-1:0]  respCycles,
  input  logic [PortW-1:0] expectByte,
  output logic [PortW-1:0] portOut,
  output logic [PortW-1:0] portOe,
  input  logic [PortW-1:0] portIn,
  output logic             testDone,
  output logic             patternMatch
);

  localparam int SampleCycles = SyncStages + 1;

  seq_ctl_t ctl;

  port_seq_ctrl #(.CntW(CntW), .SampleCycles(SampleCycles)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .respCycles (respCycles),
    .ctl        (ctl)
  );

  port_seq_data #(.PortW(PortW), .SyncStages(SyncStages)) data_i (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .stimByte     (stimByte),
    .expectByte   (expectByte),
    .portIn       (portIn),
    .portOut      (portOut),
    .portOe       (portOe),
    .testDone     (testDone),
    .patternMatch (patternMatch)
  );

  // R1/R4: enables switch as a group
  p_oe_group_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(portOe[0]) |-> portOe == '0 && portOut == '0);

endmodule

// File: tb/bidir_port_tester_tb.sv
module bidir_port_tester_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startPulse = 1'b0;
  logic [7:0]  stimByte = '0;
  logic [15:0] respCycles = '0;
  logic [7:0]  expectByte = '0;
  logic [7:0]  portOut, portOe, portIn;
  logic        testDone, patternMatch;
  logic [7:0]  devResp = '0;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  // pad model: loopback while driven, device reply when released
  always_comb portIn = (|portOe) ? portOut : devResp;

  bidir_port_tester dut_i (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .stimByte(stimByte),
    .respCycles(respCycles), .expectByte(expectByte), .portOut(portOut),
    .portOe(portOe), .portIn(portIn), .testDone(testDone),
    .patternMatch(patternMatch)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  // One full test; busyPoke strobes start and changes inputs mid-run (R7, R8)
  task automatic run_test(input logic [7:0] stim, input int n,
                          input logic [7:0] expv, input logic [7:0] resp,
                          input bit busyPoke);
    int d;
    int driveBad, oeBad, doneBad;
    d = (n < 1) ? 1 : n;
    driveBad = 0; oeBad = 0; doneBad = 0;
    @(negedge clk);
    stimByte = stim; respCycles = 16'(n); expectByte = expv;
    devResp = ~resp; startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    for (int k = 0; k <= d + 5; k++) begin
      // cycle k observed here
      if (k < d) begin
        if (portOe !== 8'hFF || portOut !== stim) driveBad++;
      end else if (portOe !== 8'h00 || portOut !== 8'h00) oeBad++;
      if (testDone !== (k == d + 4)) doneBad++;
      if (k == d + 4) check("R5", "match at done", patternMatch, resp == expv);
      if (k == d + 1) devResp = resp;
      if (k == d + 2) devResp = ~resp;
      if (busyPoke && k == 1) begin
        startPulse = 1'b1; stimByte = ~stim; expectByte = ~expv;
        respCycles = 16'(n + 7);
      end
      if (busyPoke && k == 2) startPulse = 1'b0;
      @(negedge clk);
    end
    check("R2", "drive data/enable", driveBad, 0);
    check("R3", "drive length / R4 release", oeBad, 0);
    check("R6", "done timing", doneBad, 0);
    if (busyPoke) begin
      check("R7", "no restart after busy start", portOe, 8'h00);
      check("R8", "result from original config", patternMatch, resp == expv);
    end
    // R6: match held while idle
    repeat (3) @(negedge clk);
    check("R6", "match hold", patternMatch, resp == expv);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "reset oe", portOe, 8'h00);
    check("R1", "reset done", testDone, 0);
    check("R1", "reset match", patternMatch, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "idle oe", portOe, 8'h00);

    run_test(8'hA5, 5, 8'h3C, 8'h3C, 0);   // match, normal length
    run_test(8'h5A, 0, 8'h81, 8'h80, 0);   // zero length, mismatch by one bit (R3)
    run_test(8'h11, 1, 8'hF0, 8'hF0, 0);   // length one, match
    run_test(8'h77, 3, 8'h12, 8'h77, 0);   // reply equals stimulus, not expected (R4)
    run_test(8'hC3, 4, 8'h99, 8'h99, 1);   // busy start and input change (R7, R8)

    // R6: next accepted start clears the held match
    @(negedge clk);
    stimByte = 8'h01; respCycles = 16'd2; expectByte = 8'h00; startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    check("R6", "match cleared by start", patternMatch, 0);
    repeat (10) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule